// File: doc/BRIEF.md
# I2C Bus Slave Controller with Register Interface

This block attaches a processor to a two-wire I2C bus. Software programs a 7-bit slave address and a control byte through a small register window. The block then follows the bus. It acknowledges its own address, receives or transmits data bytes, and raises an interrupt after the ninth clock of every byte it takes part in. Between bytes it holds SCL low. It lets the clock go only when software touches the data register in the direction the control register selects: a write when transmitting, a read when receiving.

The block can also be placed in master mode to shift a byte onto a bus whose clock is produced elsewhere. If a bit it leaves high is seen low on the bus, it flags lost arbitration, drops back to slave mode and stops driving. The interrupt for that byte still comes at the ninth falling clock edge. Both bus lines are open-drain. The block reads their levels and pulls them low through enable outputs. SCL generation, multi-master clock synchronisation and 10-bit addressing are not part of this block.

Register window (`cpu_addr`): 0 holds the slave address in bits 7:1. 1 is control, with bit 7 enable, bit 6 interrupt enable, bit 5 master, bit 4 transmit, and bit 3 NACK-next-byte. 2 is status, with bit 6 addressed, bit 5 bus busy, bit 4 arbitration lost, bit 2 slave direction (1 = master reads), bit 1 interrupt pending, and bit 0 received acknowledge (1 = no ACK). 3 is the data register. Reads are combinational.

Top module: `i2cs_ctrl`

## Requirements
- R1: After reset every register reads 0, both line enables are low and `irq` is low.
- R2: Address bits are sampled on SCL rising edges, MSB first, with the R/W bit eighth. If the upper seven bits equal the programmed address, the block pulls SDA low for the ninth clock and sets status bit 6 and status bit 2 (= R/W). On a mismatch it drives nothing and raises no interrupt.
- R3: Any write to the control register clears status bit 6.
- R4: At the ninth SCL falling edge of each byte handled, status bit 1 is set. `irq` equals status bit 1 AND control bit 6. Interrupts for data bytes read status bit 6 as 0.
- R5: While status bit 1 is set after a byte, `scl_oe` stays high. Only a data write with control bit 4 = 1, or a data read with control bit 4 = 0, releases it. An access in the other direction leaves it high.
- R6: In slave receive, each byte is placed in the data register and acknowledged with SDA low. When control bit 3 is 1 the byte is refused instead (SDA left high).
- R7: In slave transmit, the byte written to the data register appears on SDA MSB first. The master's ninth-clock SDA level is stored in status bit 0.
- R8: After a refused transmit byte, clearing control bit 4 and then reading the data register releases SCL, so the master can end with STOP.
- R9: In master mode, a released bit seen low on a rising SCL edge sets status bit 4 and clears control bit 5. SDA is not driven for the rest of the byte, and status bit 1 is set at that byte's ninth falling edge and not earlier.
- R10: Status bits 4 and 1 are cleared only by writing 0 to them. Writing 1 leaves them unchanged.
- R11: SDA falling while SCL is high (START) sets status bit 5. SDA rising while SCL is high (STOP) clears it and returns the block to idle with both lines released.
- R12: Writing control 0x20, then 0xA0, then reading data, then writing 0x80 leaves control reading 0x80 with SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register select |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (data read has side effects) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The embedded properties rely on three things about the inputs. Each SCL phase lasts longer than the input synchroniser delay. SDA moves only while SCL is low, except for START and STOP. Software issues at most one register access per cycle. The bench follows all three: it holds each SCL phase for ten clocks, changes SDA three clocks after it pulls SCL low, and spaces every register access over two cycles. The property tying a control write to a cleared address flag excludes the cycle in which a falling SCL edge could set that flag again.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam logic [1:0] REG_SADR = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_DATA = 2'd3;

    localparam int CB_EN   = 7;
    localparam int CB_IEN  = 6;
    localparam int CB_MSTA = 5;
    localparam int CB_MTX  = 4;
    localparam int CB_TXAK = 3;
    localparam int SB_ALOST = 4;
    localparam int SB_IPEND = 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_TX, ST_WAIT, ST_LOST
    } phase_e;

    typedef struct packed {
        phase_e     st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [7:0] dr;
        logic [6:0] sadr;
        logic       en;
        logic       ien;
        logic       msta;
        logic       mtx;
        logic       txak;
        logic       aas;
        logic       busy;
        logic       alost;
        logic       srw;
        logic       ipend;
        logic       rxak;
        logic       is_addr;
        logic       ack_drv;
        logic       stretch;
    } ctl_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_sr_q, sda_sr_q;
    logic         scl_p_q, sda_p_q;
    logic         scl_lvl;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sr_q <= '1;
                    sda_sr_q <= '1;
                end else begin
                    scl_sr_q <= scl_in;
                    sda_sr_q <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sr_q <= '1;
                    sda_sr_q <= '1;
                end else begin
                    scl_sr_q <= {scl_sr_q[TOP-1:0], scl_in};
                    sda_sr_q <= {sda_sr_q[TOP-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_sr_q[TOP];
            sda_p_q <= sda_sr_q[TOP];
        end
    end

    assign scl_lvl   = scl_sr_q[TOP];
    assign sda_lvl   = sda_sr_q[TOP];
    assign scl_rise  = scl_lvl & ~scl_p_q;
    assign scl_fall  = ~scl_lvl & scl_p_q;
    assign start_det = scl_lvl & scl_p_q & sda_p_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_p_q & ~sda_p_q & sda_lvl;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cpu_addr,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'd8;
    localparam logic [3:0] ACK_BIT  = 4'd9;

    ctl_t q, d;
    logic sda_lvl, scl_rise, scl_fall, start_w, stop_w;
    logic data_wr, data_rd;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    assign data_wr = cpu_wr && (cpu_addr == REG_DATA);
    assign data_rd = cpu_rd && (cpu_addr == REG_DATA);

    always_comb begin
        d = q;
        if (cpu_wr) begin
            case (cpu_addr)
                REG_SADR: d.sadr = cpu_wdata[7:1];
                REG_CTRL: begin
                    d.en   = cpu_wdata[CB_EN];
                    d.ien  = cpu_wdata[CB_IEN];
                    d.msta = cpu_wdata[CB_MSTA];
                    d.mtx  = cpu_wdata[CB_MTX];
                    d.txak = cpu_wdata[CB_TXAK];
                    d.aas  = 1'b0;
                end
                REG_STAT: begin
                    d.alost = q.alost & cpu_wdata[SB_ALOST];
                    d.ipend = q.ipend & cpu_wdata[SB_IPEND];
                end
                default: d.dr = cpu_wdata;
            endcase
        end
        if (q.en) begin
            if (data_wr && q.mtx && (q.st == ST_WAIT || q.msta)) begin
                d.st      = ST_TX;
                d.tx      = cpu_wdata;
                d.cnt     = '0;
                d.stretch = 1'b0;
            end else if (data_rd && !q.mtx && q.st == ST_WAIT) begin
                d.st      = ST_RX;
                d.is_addr = 1'b0;
                d.cnt     = '0;
                d.stretch = 1'b0;
            end
        end
        if (stop_w) begin
            d.busy    = 1'b0;
            d.st      = ST_IDLE;
            d.stretch = 1'b0;
            d.ack_drv = 1'b0;
        end else if (start_w) begin
            d.busy    = 1'b1;
            d.st      = ST_RX;
            d.is_addr = 1'b1;
            d.cnt     = '0;
            d.stretch = 1'b0;
            d.ack_drv = 1'b0;
        end else if (scl_rise) begin
            case (q.st)
                ST_RX: begin
                    if (q.cnt < LAST_BIT) d.sh = {q.sh[6:0], sda_lvl};
                    if (q.cnt < ACK_BIT) d.cnt = q.cnt + 4'd1;
                end
                ST_TX: begin
                    if (q.cnt < ACK_BIT) d.cnt = q.cnt + 4'd1;
                    if (q.cnt == LAST_BIT) d.rxak = sda_lvl;
                    if (q.cnt < LAST_BIT && q.msta && q.tx[7] && !sda_lvl) begin
                        d.alost = 1'b1;
                        d.msta  = 1'b0;
                        d.st    = ST_LOST;
                    end
                end
                ST_LOST: if (q.cnt < ACK_BIT) d.cnt = q.cnt + 4'd1;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (q.st)
                ST_RX: begin
                    if (q.cnt == LAST_BIT) begin
                        if (q.is_addr) begin
                            if (q.sh[7:1] == q.sadr) begin
                                d.ack_drv = 1'b1;
                                d.aas     = 1'b1;
                                d.srw     = q.sh[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.dr      = q.sh;
                            d.ack_drv = !q.txak;
                        end
                    end else if (q.cnt == ACK_BIT) begin
                        d.ack_drv = 1'b0;
                        d.ipend   = 1'b1;
                        d.stretch = 1'b1;
                        d.st      = ST_WAIT;
                    end
                end
                ST_TX: begin
                    if (q.cnt == ACK_BIT) begin
                        d.ipend   = 1'b1;
                        d.stretch = 1'b1;
                        d.st      = ST_WAIT;
                    end else begin
                        d.tx = {q.tx[6:0], 1'b1};
                    end
                end
                ST_LOST: begin
                    if (q.cnt == ACK_BIT) begin
                        d.ipend = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
        if (!q.en) begin
            d.st      = ST_IDLE;
            d.stretch = 1'b0;
            d.ack_drv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_oe = q.stretch;
    assign sda_oe = q.ack_drv | (q.st == ST_TX && !q.tx[7]);
    assign irq    = q.ipend & q.ien;

    always_comb begin
        case (cpu_addr)
            REG_SADR: cpu_rdata = {q.sadr, 1'b0};
            REG_CTRL: cpu_rdata = {q.en, q.ien, q.msta, q.mtx, q.txak, 3'b000};
            REG_STAT: cpu_rdata = {1'b0, q.aas, q.busy, q.alost, 1'b0, q.srw, q.ipend, q.rxak};
            default:  cpu_rdata = q.dr;
        endcase
    end

    AST_AAS_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.aas) |-> ($past(q.st) == ST_RX && $past(q.is_addr))); // R2
    AST_CTRL_WR_CLR_AAS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == REG_CTRL && !scl_fall) |=> !q.aas); // R3
    AST_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stretch && q.en && !stop_w && !start_w && !data_wr && !data_rd) |=> q.stretch); // R5
    AST_STRETCH_ONLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> q.st == ST_WAIT); // R5
    AST_LOST_IS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.alost) |-> !q.msta); // R9
    AST_LOST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOST) |-> !sda_oe); // R9
    AST_ALOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.alost && !(cpu_wr && cpu_addr == REG_STAT)) |=> q.alost); // R10
endmodule

// File: tb/tb_i2cs_ctrl.sv
module tb_i2cs_ctrl;
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       m_scl = 1'b0;
    logic       m_sda = 1'b0;
    logic       scl_bus, sda_bus;
    int         total = 0;
    int         bad = 0;

    always #4 clk = ~clk;

    assign scl_bus = ~(scl_oe | m_scl);
    assign sda_bus = ~(sda_oe | m_sda);

    i2cs_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic bus_bit(input logic b, output logic r);
        m_sda = ~b;
        tick(HALF);
        m_scl = 1'b0;
        wait (scl_bus === 1'b1);
        tick(HALF);
        r = sda_bus;
        m_scl = 1'b1;
        tick(3);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(HALF);
        m_scl = 1'b1;
        tick(3);
    endtask

    task automatic bus_stop();
        m_sda = 1'b1;
        tick(HALF);
        m_scl = 1'b0;
        wait (scl_bus === 1'b1);
        tick(HALF);
        m_sda = 1'b0;
        tick(HALF);
    endtask

    task automatic bus_send(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
        bus_bit(1'b1, ack);
    endtask

    task automatic bus_recv(input logic nack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            v[i] = r;
        end
        bus_bit(nack, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, got, exp_b;
        logic       ack, rw, match;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 irq", irq, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd2, v); chk("R1 stat", v, 8'h00);
        rd(2'd3, v); chk("R1 data", v, 8'h00);

        // R12 recovery sequence
        wr(2'd1, 8'h20);
        wr(2'd1, 8'hA0);
        rd(2'd3, v);
        wr(2'd1, 8'h80);
        rd(2'd1, v); chk("R12 ctrl", v, 8'h80);
        chk("R12 scl released", scl_oe, 0);

        wr(2'd0, 8'hB4);
        wr(2'd1, 8'hC0);

        // R2 / R11 sweep over every 7-bit address
        for (int a = 0; a < 128; a++) begin
            rw = a[1];
            match = (a == 8'h5A);
            bus_start();
            rd(2'd2, v); chk("R11 busy after start", v[5], 1);
            bus_send({a[6:0], rw}, ack);
            chk("R2 ack level", ack, !match);
            tick(6);
            chk("R4 irq on own address", irq, match);
            if (match) begin
                rd(2'd2, v); chk("R2 aas/srw", v & 8'h44, {1'b0, 1'b1, 3'b000, rw, 2'b00});
                wr(2'd1, rw ? 8'hD0 : 8'hC0);
                rd(2'd2, v); chk("R3 aas cleared", v[6], 0);
                wr(2'd2, 8'h00);
                if (rw) wr(2'd3, 8'hFF); else rd(2'd3, v);
            end
            bus_stop();
            tick(6);
            rd(2'd2, v); chk("R11 busy after stop", v[5], 0);
            chk("R11 lines released", {scl_oe, sda_oe}, 2'b00);
        end
        wr(2'd1, 8'hC0);

        // R6 slave receive with refusal of the last byte
        bus_start();
        bus_send(8'hB4, ack); chk("R2 ack write addr", ack, 0);
        tick(6);
        rd(2'd2, v); chk("R2 aas srw=0", v & 8'h46, 8'h42);
        wr(2'd1, 8'hC0);
        wr(2'd2, 8'h00);
        rd(2'd3, v);
        for (int n = 0; n < 4; n++) begin
            exp_b = 8'(n * 8'h53 + 8'h1D);
            bus_send(exp_b, ack);
            chk("R6 ack per byte", ack, (n == 3));
            tick(6);
            chk("R4 irq after data", irq, 1);
            rd(2'd2, v); chk("R4 aas zero on data", v[6], 0);
            chk("R5 scl held", scl_oe, 1);
            wr(2'd2, 8'h00);
            if (n == 2) wr(2'd1, 8'hC8);
            rd(2'd3, v); chk("R6 data byte", v, exp_b);
            tick(2); chk("R5 released by read", scl_oe, 0);
        end
        bus_stop();
        wr(2'd1, 8'hC0);

        // R7 / R8 slave transmit ended by NACK
        bus_start();
        bus_send(8'hB5, ack); chk("R2 ack read addr", ack, 0);
        tick(6);
        rd(2'd2, v); chk("R2 srw=1", v[2], 1);
        wr(2'd1, 8'hD0);
        wr(2'd2, 8'h00);
        rd(2'd3, v);
        tick(3); chk("R5 wrong-direction read keeps hold", scl_oe, 1);
        for (int n = 0; n < 4; n++) begin
            exp_b = 8'(n * 8'h6B + 8'hA4);
            wr(2'd3, exp_b);
            tick(2); chk("R5 released by write", scl_oe, 0);
            bus_recv((n == 3), got);
            chk("R7 byte on SDA", got, exp_b);
            tick(6);
            rd(2'd2, v); chk("R7 rxak", v[0], (n == 3));
            chk("R4 irq after tx byte", irq, 1);
            wr(2'd2, 8'h00);
        end
        wr(2'd1, 8'hC0);
        rd(2'd3, v);
        tick(2); chk("R8 dummy read releases", scl_oe, 0);
        bus_stop();
        tick(6);
        rd(2'd2, v); chk("R8 busy clear after stop", v[5], 0);
        chk("R8 sda released", sda_oe, 0);

        // R9 / R10 arbitration loss at each bit position
        for (int k = 0; k < 8; k++) begin
            bus_start();
            wr(2'd1, 8'hF0);
            wr(2'd3, 8'hFF);
            exp_b = ~(8'h80 >> k);
            for (int i = 7; i >= 0; i--) bus_bit(exp_b[i], ack);
            tick(6);
            chk("R9 no irq before ninth", irq, 0);
            chk("R9 no sda drive", sda_oe, 0);
            bus_bit(1'b1, ack);
            tick(6);
            chk("R9 irq at ninth", irq, 1);
            rd(2'd2, v); chk("R9 alost", v[4], 1);
            rd(2'd1, v); chk("R9 master cleared", v[5], 0);
            wr(2'd2, 8'h12);
            rd(2'd2, v); chk("R10 write 1 keeps flags", v & 8'h12, 8'h12);
            wr(2'd2, 8'h00);
            rd(2'd2, v); chk("R10 write 0 clears flags", v & 8'h12, 8'h00);
            bus_stop();
            wr(2'd1, 8'hC0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule